// File: doc/BRIEF.md
# I2C Target Controller with Clock-Stretch Handshake

This block is the target (slave) side of an I2C bus. It oversamples SCL and SDA on the system clock, recognises START, repeated START and STOP, shifts in the address byte and then moves data bytes to or from a local host. It never drives the bus high. SCL and SDA are driven only through pull-down enables, which feed open-drain pads.

Every event that needs the host holds the bus clock low until the host replies. The events are an accepted address, a STOP, and each finished data byte. The host reads the status and data outputs. It loads the next byte to send and then pulses a single command strobe. The strobe carries the ACK/NACK decision and releases SCL. Address events and STOP events share one flag, and data bytes have a flag of their own. The host therefore never has to poll the bus timing.

Top module: `i2c_tgt`

## Requirements
- R1: After reset, and while `cfg_en` is low, both pull-down enables and both event flags are 0. The bus is ignored while `cfg_en` is low, so a transfer to the programmed address is not acknowledged.
- R2: After a START, the block shifts in 8 address bits MSB first, with the last bit giving the direction (1 = read). When the upper 7 bits equal `cfg_addr`, `evt_addr` is set, `st_stop` reads 0 and `st_dir` shows the direction bit. A command with `cmd_nack`=0 then pulls SDA low for the 9th clock.
- R3: A non-matching address is not acknowledged and raises no event. Every further byte is ignored, with no ACK and no event, until the next START.
- R4: With `cfg_promisc` high, every address is accepted as in R2.
- R5: The general call byte 0x00 (address 0, write) is accepted as in R2 even when it differs from `cfg_addr`.
- R6: In a write transfer, each received byte appears on `rx_data` and sets `evt_data`. The ninth bit is ACK when the host's command has `cmd_nack`=0 and NACK when it is 1. After a NACK, the block ignores the bus until START or STOP.
- R7: In a read transfer, `tx_data` is sent MSB first. The master's ninth bit is kept in `st_rxnack` (1 = NACK). On an ACK, `evt_data` is set and the host supplies the next byte. On a NACK, no event is raised and SDA is released.
- R8: SCL is held low and `st_hold` is 1 exactly while an event flag is set. The two flags are never set together. A `cmd_valid` pulse clears the flag, which reads 0 on the following cycle.
- R9: With `cfg_stop_evt` high, a STOP that ends any activity since a START sets `evt_addr` with `st_stop`=1. With `cfg_stop_evt` low, a STOP raises no event.
- R10: A START followed directly by a STOP, with no address bit in between, sets `st_buserr` and returns the block to idle. The next START clears it.
- R11: When the block releases SDA for a data bit but samples SDA low at the SCL rising edge, `st_coll` is set and the block stops driving SDA until the next START, which clears `st_coll`.
- R12: A repeated START in any state restarts address reception from the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| scl_pd | output | 1 | Pull SCL low (clock stretch) |
| sda_pd | output | 1 | Pull SDA low |
| cfg_en | input | 1 | Enable the target |
| cfg_addr | input | 7 | Own 7-bit address |
| cfg_promisc | input | 1 | Accept every address |
| cfg_stop_evt | input | 1 | Raise the address/stop event on STOP |
| tx_data | input | 8 | Byte to send in a read transfer |
| rx_data | output | 8 | Last byte received |
| evt_addr | output | 1 | Address or STOP event pending |
| evt_data | output | 1 | Data byte event pending |
| cmd_valid | input | 1 | Host response strobe, clears the pending flag |
| cmd_nack | input | 1 | Host decision with the strobe: 1 = NACK |
| st_hold | output | 1 | SCL is being held low |
| st_rxnack | output | 1 | Last ninth bit from the master (1 = NACK) |
| st_coll | output | 1 | SDA collision seen |
| st_buserr | output | 1 | START directly followed by STOP |
| st_dir | output | 1 | Direction of current transfer (1 = read) |
| st_stop | output | 1 | Pending `evt_addr` comes from a STOP |

## Verification
Two functions can complete in the same clock cycle: bus-error detection and the STOP event. A START followed directly by a STOP, with STOP events enabled, must raise `st_buserr` and the STOP-flavoured `evt_addr` on the same edge. The bench provokes this by toggling SDA twice while SCL stays high. It then expects both the bus-error status and a scoreboard entry marked as a STOP, and the entry must be released by the host command. A master model on a wired-AND bus with clock stretching drives the other tests. A host model pops the expected events from the scoreboard queue as the flags rise.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared widths and the controller state type for the I2C target.
// Assumes 7-bit addressing and byte-wide data.
package i2c_tgt_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,   // waiting for START
        ST_ADDR,   // shifting address byte
        ST_AHOLD,  // address accepted, stretching for host
        ST_AACK,   // driving address ACK
        ST_RXD,    // receiving data bits
        ST_DHOLD,  // data byte done, stretching for host
        ST_DACK,   // driving data ACK/NACK
        ST_TXD,    // sending data bits
        ST_TACK,   // sampling master ACK/NACK
        ST_WAIT    // off the bus until START or STOP
    } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
// Module: two-flop (parameterised) synchroniser for SCL/SDA plus bus
// condition detection. START/STOP are SDA edges while synchronised SCL is
// high on both the current and previous sample. Assumes clk >> SCL rate.
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic cond_start,
    output logic cond_stop
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    // Synchroniser chains, idle-high after reset.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    // Previous synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge and condition decode.
    always_comb begin
        scl_rise   = scl_s & ~scl_q;
        scl_fall   = ~scl_s & scl_q;
        cond_start = scl_s & scl_q & sda_q & ~sda_s;
        cond_stop  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_tgt_match.sv
// Module: address acceptance. Accepts own address, the general call byte
// (all zeros, write) or anything in promiscuous mode. Purely combinational.
module i2c_tgt_match
    import i2c_tgt_pkg::*;
(
    input  logic [DATA_W-1:0] addr_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              promisc,
    output logic              hit
);
    // Acceptance decision.
    always_comb begin
        hit = promisc
            | (addr_byte[DATA_W-1:1] == own_addr)
            | (addr_byte == '0);
    end
endmodule

// File: rtl/i2c_tgt_ctrl.sv
// Module: target protocol sequencer. Consumes decoded bus edges and
// conditions, runs the byte/ACK sequence, raises stretch events and drives
// the SDA pull-down. Assumes SDA only changes while SCL is low except for
// START/STOP.
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_stop_evt,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              cond_start,
    input  logic              cond_stop,
    input  logic              addr_hit,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              cmd_valid,
    input  logic              cmd_nack,
    output logic [DATA_W-1:0] shift_q,
    output logic [DATA_W-1:0] rx_data,
    output logic              evt_addr,
    output logic              evt_data,
    output logic              sda_pd,
    output logic              st_rxnack,
    output logic              st_coll,
    output logic              st_buserr,
    output logic              st_dir,
    output logic              st_stop
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    tgt_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             ack_q;

    // Protocol state, event flags and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_en) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            ack_q     <= 1'b0;
            shift_q   <= '0;
            evt_addr  <= 1'b0;
            evt_data  <= 1'b0;
            st_coll   <= 1'b0;
            st_buserr <= 1'b0;
            st_stop   <= 1'b0;
            if (!rst_n) begin
                rx_data   <= '0;
                st_rxnack <= 1'b0;
                st_dir    <= 1'b0;
            end
        end else begin
            if (cmd_valid) begin
                evt_addr <= 1'b0;
                evt_data <= 1'b0;
            end
            if (cond_start) begin
                state     <= ST_ADDR;
                cnt       <= '0;
                st_coll   <= 1'b0;
                st_buserr <= 1'b0;
                evt_data  <= 1'b0;
            end else if (cond_stop) begin
                if (state == ST_ADDR && cnt == '0)
                    st_buserr <= 1'b1;
                if (state != ST_IDLE && cfg_stop_evt) begin
                    evt_addr <= 1'b1;
                    st_stop  <= 1'b1;
                end
                evt_data <= 1'b0;
                state    <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shift_q <= {shift_q[DATA_W-2:0], sda_s};
                            cnt     <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST) begin
                            if (addr_hit) begin
                                evt_addr <= 1'b1;
                                st_stop  <= 1'b0;
                                st_dir   <= shift_q[0];
                                state    <= ST_AHOLD;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_AHOLD: if (cmd_valid) state <= cmd_nack ? ST_WAIT : ST_AACK;
                    ST_AACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (st_dir) begin
                                shift_q <= tx_data;
                                state   <= ST_TXD;
                            end else begin
                                state <= ST_RXD;
                            end
                        end
                    end
                    ST_RXD: begin
                        if (scl_rise) begin
                            shift_q <= {shift_q[DATA_W-2:0], sda_s};
                            cnt     <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST) begin
                            rx_data  <= shift_q;
                            evt_data <= 1'b1;
                            state    <= ST_DHOLD;
                        end
                    end
                    ST_DHOLD: begin
                        if (cmd_valid) begin
                            cnt <= '0;
                            if (st_dir) begin
                                shift_q <= tx_data;
                                state   <= ST_TXD;
                            end else begin
                                ack_q <= ~cmd_nack;
                                state <= ST_DACK;
                            end
                        end
                    end
                    ST_DACK: if (scl_fall) state <= ack_q ? ST_RXD : ST_WAIT;
                    ST_TXD: begin
                        if (scl_rise) begin
                            if (shift_q[DATA_W-1] && !sda_s) begin
                                st_coll <= 1'b1;
                                state   <= ST_WAIT;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end else if (scl_fall) begin
                            shift_q <= {shift_q[DATA_W-2:0], 1'b1};
                            if (cnt == LAST) state <= ST_TACK;
                        end
                    end
                    ST_TACK: begin
                        if (scl_rise) begin
                            st_rxnack <= sda_s;
                        end else if (scl_fall) begin
                            if (st_rxnack) begin
                                state <= ST_WAIT;
                            end else begin
                                evt_data <= 1'b1;
                                state    <= ST_DHOLD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // SDA pull-down: address ACK, data ACK, or a zero data bit.
    always_comb begin
        sda_pd = cfg_en & ((state == ST_AACK)
                         | (state == ST_DACK && ack_q)
                         | (state == ST_TXD && !shift_q[DATA_W-1]));
    end
endmodule

// File: rtl/i2c_tgt.sv
// Module: top of the I2C target. Wires synchroniser, address matcher and
// sequencer; SCL is pulled low whenever an event flag awaits the host.
// Assumes external open-drain pads driven from scl_pd/sda_pd.
module i2c_tgt
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_pd,
    output logic              sda_pd,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_promisc,
    input  logic              cfg_stop_evt,
    input  logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] rx_data,
    output logic              evt_addr,
    output logic              evt_data,
    input  logic              cmd_valid,
    input  logic              cmd_nack,
    output logic              st_hold,
    output logic              st_rxnack,
    output logic              st_coll,
    output logic              st_buserr,
    output logic              st_dir,
    output logic              st_stop
);
    logic              scl_s, sda_s, scl_rise, scl_fall, cond_start, cond_stop;
    logic              addr_hit;
    logic [DATA_W-1:0] shift_q;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk, .rst_n, .scl_i, .sda_i,
        .scl_s, .sda_s, .scl_rise, .scl_fall, .cond_start, .cond_stop
    );

    i2c_tgt_match u_match (
        .addr_byte(shift_q), .own_addr(cfg_addr), .promisc(cfg_promisc), .hit(addr_hit)
    );

    i2c_tgt_ctrl u_ctrl (
        .clk, .rst_n, .cfg_en, .cfg_stop_evt, .sda_s, .scl_rise, .scl_fall,
        .cond_start, .cond_stop, .addr_hit, .tx_data, .cmd_valid, .cmd_nack,
        .shift_q, .rx_data, .evt_addr, .evt_data, .sda_pd, .st_rxnack,
        .st_coll, .st_buserr, .st_dir, .st_stop
    );

    // Clock stretch request: any pending event holds SCL.
    always_comb begin
        scl_pd  = evt_addr | evt_data;
        st_hold = scl_pd;
    end
endmodule

// File: rtl/i2c_tgt_chk.sv
// Module: protocol checker bound to i2c_tgt; observes ports only.
module i2c_tgt_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_en,
    input logic scl_pd,
    input logic sda_pd,
    input logic evt_addr,
    input logic evt_data,
    input logic cmd_valid,
    input logic st_coll,
    input logic st_buserr
);
    a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_addr && evt_data));

    a_r8_data_release: assert property (@(posedge clk) disable iff (!rst_n)
        evt_data && cmd_valid |=> !evt_data);

    a_r8_addr_persist: assert property (@(posedge clk) disable iff (!rst_n)
        evt_addr && !cmd_valid && cfg_en |=> evt_addr);

    a_r1_disable_frees_scl: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !scl_pd);

    a_r11_coll_releases_sda: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_coll) |-> !sda_pd);

    a_r10_buserr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_buserr) |-> !sda_pd && !evt_data);
endmodule

bind i2c_tgt i2c_tgt_chk u_chk (.*);

// File: tb/i2c_tgt_tb.sv
`timescale 1ns/1ps
module i2c_tgt_tb;
    localparam int HALF = 12;
    localparam logic [6:0] OWN = 7'h3A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       scl_pd, sda_pd;
    wire        scl_bus = m_scl & ~scl_pd;
    wire        sda_bus = m_sda & ~sda_pd;
    logic       cfg_en = 1'b0, cfg_promisc = 1'b0, cfg_stop_evt = 1'b0;
    logic [6:0] cfg_addr = OWN;
    logic [7:0] tx_data = 8'h00, rx_data;
    logic       evt_addr, evt_data, cmd_valid = 1'b0, cmd_nack = 1'b0;
    logic       st_hold, st_rxnack, st_coll, st_buserr, st_dir, st_stop;

    i2c_tgt u_dut (
        .clk, .rst_n, .scl_i(scl_bus), .sda_i(sda_bus), .scl_pd, .sda_pd,
        .cfg_en, .cfg_addr, .cfg_promisc, .cfg_stop_evt, .tx_data, .rx_data,
        .evt_addr, .evt_data, .cmd_valid, .cmd_nack, .st_hold, .st_rxnack,
        .st_coll, .st_buserr, .st_dir, .st_stop
    );

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    bit host_nack_addr = 1'b0, host_nack_data = 1'b0;
    // scoreboard entry: {kind[1:0], payload[7:0]}; kind 0 addr {stop,dir}, 1 rx byte, 2 tx ack
    logic [9:0] exp_q[$];
    logic [7:0] tx_q[$];

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; tick(HALF / 2);
        m_scl = 1'b1; wait_scl_high(); tick(HALF);
        m_sda = 1'b0; tick(HALF);
        m_scl = 1'b0; tick(HALF / 2);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; tick(HALF / 2);
        m_scl = 1'b1; wait_scl_high(); tick(HALF);
        m_sda = 1'b1; tick(HALF);
    endtask

    task automatic m_bit_w(input logic b);
        m_sda = b; tick(HALF / 2);
        m_scl = 1'b1; wait_scl_high(); tick(HALF);
        m_scl = 1'b0; tick(HALF / 2);
    endtask

    task automatic m_bit_r(output logic b);
        m_sda = 1'b1; tick(HALF / 2);
        m_scl = 1'b1; wait_scl_high(); tick(HALF / 2);
        b = sda_bus; tick(HALF / 2);
        m_scl = 1'b0; tick(HALF / 2);
    endtask

    task automatic m_write(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) m_bit_w(d[i]);
        m_bit_r(b);
        acked = ~b;
    endtask

    task automatic m_read(output logic [7:0] d, input logic nack);
        for (int i = 7; i >= 0; i--) m_bit_r(d[i]);
        m_bit_w(nack);
    endtask

    // Host model / scoreboard monitor: answers every stretch event.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (evt_addr || evt_data)) begin
                tick(4);
                check("R8", "scl held during event", {scl_pd, st_hold}, 2'b11);
                if (exp_q.size() == 0) begin
                    check("R3", "unexpected event", {evt_addr, evt_data}, 2'b00);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    if (evt_addr) begin
                        check("R2", "event kind", 2'd0, e[9:8]);
                        check("R9", "stop marker", st_stop, e[1]);
                        if (!e[1]) check("R2", "direction", st_dir, e[0]);
                    end else if (!st_dir) begin
                        check("R6", "event kind", 2'd1, e[9:8]);
                        check("R6", "rx byte", rx_data, e[7:0]);
                    end else begin
                        check("R7", "event kind", 2'd2, e[9:8]);
                    end
                end
                if (st_dir && !(evt_addr && st_stop) && tx_q.size() > 0) tx_data = tx_q.pop_front();
                cmd_nack  = evt_addr ? host_nack_addr : host_nack_data;
                cmd_valid = 1'b1;
                @(negedge clk);
                cmd_valid = 1'b0;
                check("R8", "flags clear after command", {evt_addr, evt_data, scl_pd}, 3'b000);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic       a;
        logic [7:0] d;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        check("R1", "reset outputs", {scl_pd, sda_pd, evt_addr, evt_data, st_coll, st_buserr, st_rxnack},
              7'b0);
        cfg_en = 1'b1;
        tick(10);

        // R2/R6: write two bytes to own address
        exp_q.push_back({2'd0, 8'h00});
        exp_q.push_back({2'd1, 8'hA5});
        exp_q.push_back({2'd1, 8'h3C});
        m_start();
        m_write({OWN, 1'b0}, a); check("R2", "address ack", a, 1'b1);
        m_write(8'hA5, a);       check("R6", "data ack", a, 1'b1);
        m_write(8'h3C, a);       check("R6", "data ack 2", a, 1'b1);
        m_stop(); tick(40);

        // R6: host NACKs a data byte
        host_nack_data = 1'b1;
        exp_q.push_back({2'd0, 8'h00});
        exp_q.push_back({2'd1, 8'h11});
        m_start();
        m_write({OWN, 1'b0}, a);
        m_write(8'h11, a); check("R6", "host nack seen", a, 1'b0);
        m_stop(); tick(40);
        host_nack_data = 1'b0;

        // R7: read two bytes, ACK then NACK
        tx_q.push_back(8'hC3); tx_q.push_back(8'h5A);
        exp_q.push_back({2'd0, 8'h01});
        exp_q.push_back({2'd2, 8'h00});
        m_start();
        m_write({OWN, 1'b1}, a); check("R2", "read address ack", a, 1'b1);
        m_read(d, 1'b0); check("R7", "tx byte 1", d, 8'hC3);
        check("R7", "rxnack after ack", st_rxnack, 1'b0);
        m_read(d, 1'b1); check("R7", "tx byte 2", d, 8'h5A);
        tick(4);
        check("R7", "nack recorded, sda free", {st_rxnack, sda_pd}, 2'b10);
        m_stop(); tick(40);

        // R3: mismatching address and following byte ignored
        m_start();
        m_write({7'h12, 1'b0}, a); check("R3", "no address ack", a, 1'b0);
        m_write(8'h77, a);         check("R3", "no data ack", a, 1'b0);
        m_stop(); tick(40);
        check("R3", "no event raised", exp_q.size(), 0);

        // R4: promiscuous
        cfg_promisc = 1'b1;
        exp_q.push_back({2'd0, 8'h00});
        exp_q.push_back({2'd1, 8'h99});
        m_start();
        m_write({7'h12, 1'b0}, a); check("R4", "promisc ack", a, 1'b1);
        m_write(8'h99, a);
        m_stop(); tick(40);
        cfg_promisc = 1'b0;

        // R5: general call
        exp_q.push_back({2'd0, 8'h00});
        exp_q.push_back({2'd1, 8'h42});
        m_start();
        m_write(8'h00, a); check("R5", "general call ack", a, 1'b1);
        m_write(8'h42, a);
        m_stop(); tick(40);

        // R12: repeated START after partial address
        exp_q.push_back({2'd0, 8'h00});
        exp_q.push_back({2'd1, 8'h6E});
        m_start();
        m_bit_w(1'b1); m_bit_w(1'b0); m_bit_w(1'b1);
        m_start();
        m_write({OWN, 1'b0}, a); check("R12", "ack after restart", a, 1'b1);
        m_write(8'h6E, a);
        m_stop(); tick(40);

        // R9: STOP event enabled
        cfg_stop_evt = 1'b1;
        exp_q.push_back({2'd0, 8'h00});
        exp_q.push_back({2'd1, 8'h01});
        exp_q.push_back({2'd0, 8'h02});
        m_start();
        m_write({OWN, 1'b0}, a);
        m_write(8'h01, a);
        m_stop(); tick(40);
        check("R9", "stop event consumed", exp_q.size(), 0);

        // R10 + R9 same cycle: START directly followed by STOP
        exp_q.push_back({2'd0, 8'h02});
        m_scl = 1'b1; m_sda = 1'b1; tick(HALF);
        m_sda = 1'b0; tick(HALF);
        m_sda = 1'b1; tick(HALF);
        check("R10", "bus error flagged", st_buserr, 1'b1);
        tick(40);
        check("R10", "bus error stop event consumed", exp_q.size(), 0);
        cfg_stop_evt = 1'b0;

        // R11: collision during read; also R10 clear on START
        tx_q.push_back(8'hFF);
        exp_q.push_back({2'd0, 8'h01});
        m_start();
        check("R10", "bus error cleared by START", st_buserr, 1'b0);
        m_write({OWN, 1'b1}, a);
        m_bit_w(1'b0);
        check("R11", "collision, sda released", {st_coll, sda_pd}, 2'b10);
        m_bit_w(1'b1);
        check("R11", "still off the bus", sda_pd, 1'b0);
        m_stop(); tick(40);
        m_start();
        check("R11", "collision cleared by START", st_coll, 1'b0);
        m_stop(); tick(40);

        // R1: disabled block ignores its own address
        cfg_en = 1'b0; tick(4);
        m_start();
        m_write({OWN, 1'b0}, a); check("R1", "disabled no ack", a, 1'b0);
        m_stop(); tick(40);
        check("R1", "disabled no event", {evt_addr, evt_data, scl_pd}, 3'b000);
        cfg_en = 1'b1;

        check("R3", "scoreboard empty", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule